// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This unit compares two 64-bit IEEE-754 double-precision operands and returns a 64-bit boolean word. A two-bit function code picks one of four tests: unordered, equal, less-than or less-or-equal. The word for "true" has a single fixed bit set, so a later stage can use it directly as a floating-point register value. Alongside the result the unit raises an invalid-operation flag and a denormal-operand flag. Both flags are valid in the same cycle as the result.

Each operand is first classified as zero, denormal, quiet NaN or signaling NaN. When the flush control is high, a denormal operand loses its fraction, so it compares as a zero of the same sign. Ordered operands are ranked by sign-magnitude rules, and the two signed zeros are treated as one value. A parameter selects between a purely combinational variant and one with a single register stage. The register stage has an `in_valid`/`out_valid` handshake.

Top module: `dfp_compare_unit`

## Requirements
- R1: `func_sel` encodes the test: 2'd0 unordered, 2'd1 equal, 2'd2 less-than (A < B), 2'd3 less-or-equal (A <= B).
- R2: A true result is the 64-bit word with only bit 62 set (64'h4000_0000_0000_0000). A false result is all zeros.
- R3: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. The unordered test is true exactly when at least one operand is a NaN. The other three tests are false for such a pair.
- R4: `flag_invalid` is raised only for an unordered pair, and then only if the function is less-than or less-or-equal, or if either operand is a signaling NaN.
- R5: `flag_denorm` is raised when either operand has a zero exponent field and a nonzero fraction. This holds for every function and for either setting of `flush_den`.
- R6: With `flush_den` high, a denormal operand compares as a zero of the same sign. With it low, the denormal compares by its true magnitude.
- R7: +0 and -0 compare equal, and neither is less than the other.
- R8: A NaN is signaling when fraction bit 51 is 0, and quiet when that bit is 1.
- R9: Non-NaN operands are ordered by sign and magnitude. Any negative value is below any positive value. Among negatives, the larger magnitude is the smaller value. The infinities bound all finite values.
- R10: With `REG_OUT`=1, the result and both flags appear together one clock after `in_valid` is sampled high, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low one clock later. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and function are valid this cycle |
| func_sel | input | 2 | Compare function code |
| flush_den | input | 1 | Treat denormal operands as signed zero |
| opa | input | 64 | Operand A, IEEE double |
| opb | input | 64 | Operand B, IEEE double |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Boolean result word |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_denorm | output | 1 | Denormal-operand exception |

## Verification
The assertions assume that `opa`, `opb`, `func_sel` and `flush_den` carry known values whenever `in_valid` is high. They also assume that `in_valid` itself is never unknown after reset. The stimulus meets these conditions: every input is driven to a defined value from time zero, and reset is held for several cycles. The sweep crosses a list of special operands with every function and both flush settings. The random pairs are biased towards all-zero and all-ones exponents, so that NaNs, infinities and denormals often meet ordinary values.

// File: rtl/dfp_cmp_pkg.sv
package dfp_cmp_pkg;

   typedef enum logic [1:0] {
      CMPF_UNORD = 2'd0,
      CMPF_EQ    = 2'd1,
      CMPF_LT    = 2'd2,
      CMPF_LE    = 2'd3
   } cmp_func_e;

   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_den;
      logic is_nan;
      logic is_snan;
   } opnd_class_t;

endpackage

// File: rtl/dfp_cmp_classify.sv
module dfp_cmp_classify
   import dfp_cmp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MAG_W  = EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] op,
   input  logic              flush,
   output opnd_class_t       cls,
   output logic [MAG_W-1:0]  mag
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic [FRAC_W-1:0] frac_eff;
   logic              exp_zero;
   logic              exp_ones;
   logic              frac_nz;

   assign exp_f    = op[WORD_W-2 -: EXP_W];
   assign frac_f   = op[FRAC_W-1:0];
   assign exp_zero = (exp_f == '0);
   assign exp_ones = (exp_f == '1);
   assign frac_nz  = (frac_f != '0);

   // a flushed denormal keeps its sign but loses its fraction
   assign frac_eff = (flush && exp_zero) ? '0 : frac_f;

   always_comb begin
      cls.sign    = op[WORD_W-1];
      cls.is_den  = exp_zero && frac_nz;
      cls.is_zero = exp_zero && (frac_eff == '0);
      cls.is_nan  = exp_ones && frac_nz;
      cls.is_snan = exp_ones && frac_nz && !frac_f[FRAC_W-1];
   end

   assign mag = {exp_f, frac_eff};

endmodule

// File: rtl/dfp_cmp_order.sv
module dfp_cmp_order #(
   parameter int MAG_W = 63
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             eq,
   output logic             lt
);

   logic mag_eq;
   logic mag_lt;

   assign mag_eq = (mag_a == mag_b);
   assign mag_lt = (mag_a <  mag_b);

   always_comb begin
      if (zero_a && zero_b) begin
         eq = 1'b1;
         lt = 1'b0;
      end else if (sign_a != sign_b) begin
         eq = 1'b0;
         lt = sign_a;
      end else if (!sign_a) begin
         eq = mag_eq;
         lt = mag_lt;
      end else begin
         eq = mag_eq;
         lt = !mag_lt && !mag_eq;
      end
   end

endmodule

// File: rtl/dfp_cmp_select.sv
module dfp_cmp_select
   import dfp_cmp_pkg::*;
(
   input  logic [1:0] func,
   input  logic       unord,
   input  logic       snan_any,
   input  logic       eq,
   input  logic       lt,
   output logic       hit,
   output logic       invalid
);

   cmp_func_e fn;
   assign fn = cmp_func_e'(func);

   always_comb begin
      hit = 1'b0;
      if (unord) begin
         hit = (fn == CMPF_UNORD);
      end else begin
         case (fn)
            CMPF_EQ: hit = eq;
            CMPF_LT: hit = lt;
            CMPF_LE: hit = lt || eq;
            default: hit = 1'b0;
         endcase
      end
   end

   // ordered tests trap on any NaN, the others only on signaling ones
   assign invalid = unord && ((fn == CMPF_LT) || (fn == CMPF_LE) || snan_any);

endmodule

// File: rtl/dfp_compare_unit.sv
module dfp_compare_unit
   import dfp_cmp_pkg::*;
#(
   parameter int EXP_W    = 11,
   parameter int FRAC_W   = 52,
   parameter int TRUE_BIT = 62,
   parameter bit REG_OUT  = 1'b1,
   localparam int WORD_W  = 1 + EXP_W + FRAC_W,
   localparam int MAG_W   = EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        func_sel,
   input  logic              flush_den,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic              out_valid,
   output logic [WORD_W-1:0] result,
   output logic              flag_invalid,
   output logic              flag_denorm
);

   localparam logic [WORD_W-1:0] TRUE_WORD = WORD_W'(1) << TRUE_BIT;

   if (EXP_W < 2) begin : g_bad_exp
      $error("dfp_compare_unit: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("dfp_compare_unit: FRAC_W must be at least 2");
   end
   if (TRUE_BIT < 0 || TRUE_BIT >= WORD_W) begin : g_bad_true
      $error("dfp_compare_unit: TRUE_BIT outside the word");
   end

   logic [WORD_W-1:0] ops [2];
   opnd_class_t       cls [2];
   logic [MAG_W-1:0]  mag [2];

   assign ops[0] = opa;
   assign ops[1] = opb;

   for (genvar i = 0; i < 2; i++) begin : g_cls
      dfp_cmp_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .op    (ops[i]),
         .flush (flush_den),
         .cls   (cls[i]),
         .mag   (mag[i])
      );
   end

   logic c_eq, c_lt, c_unord, c_hit, c_inv, c_den;

   dfp_cmp_order #(.MAG_W(MAG_W)) u_ord (
      .sign_a (cls[0].sign),
      .sign_b (cls[1].sign),
      .zero_a (cls[0].is_zero),
      .zero_b (cls[1].is_zero),
      .mag_a  (mag[0]),
      .mag_b  (mag[1]),
      .eq     (c_eq),
      .lt     (c_lt)
   );

   assign c_unord = cls[0].is_nan || cls[1].is_nan;
   assign c_den   = cls[0].is_den || cls[1].is_den;

   dfp_cmp_select u_sel (
      .func     (func_sel),
      .unord    (c_unord),
      .snan_any (cls[0].is_snan || cls[1].is_snan),
      .eq       (c_eq),
      .lt       (c_lt),
      .hit      (c_hit),
      .invalid  (c_inv)
   );

   logic [WORD_W-1:0] c_word;
   assign c_word = c_hit ? TRUE_WORD : '0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result       <= c_word;
               flag_invalid <= c_inv;
               flag_denorm  <= c_den;
            end
         end
      end

      assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end else begin : g_comb
      assign out_valid    = in_valid;
      assign result       = c_word;
      assign flag_invalid = c_inv;
      assign flag_denorm  = c_den;
   end

   assert_unord_blocks_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_unord) |-> (!c_hit || func_sel == 2'd0));
   assert_eq_lt_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !(c_eq && c_lt));
   assert_invalid_needs_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && flag_invalid == 1'b0 && c_inv) |-> c_unord);
   assert_denorm_zero_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_den) |-> (opa[WORD_W-2 -: EXP_W] == '0 || opb[WORD_W-2 -: EXP_W] == '0));
   assert_signed_zero_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opa[WORD_W-2:0] == '0 && opb[WORD_W-2:0] == '0) |-> (c_eq && !c_lt));
   assert_word_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result == '0 || result == TRUE_WORD));

endmodule

// File: tb/dfp_compare_unit_test.sv
module dfp_compare_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] TRUE_W = 64'h4000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  func_sel = 2'd0;
   logic        flush_den = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        flag_invalid;
   logic        flag_denorm;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dfp_compare_unit uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .func_sel     (func_sel),
      .flush_den    (flush_den),
      .opa          (opa),
      .opb          (opb),
      .out_valid    (out_valid),
      .result       (result),
      .flag_invalid (flag_invalid),
      .flag_denorm  (flag_denorm)
   );

   logic [63:0] corner [16];
   initial begin
      corner[0]  = 64'h0000_0000_0000_0000; // +0
      corner[1]  = 64'h8000_0000_0000_0000; // -0
      corner[2]  = 64'h3FF0_0000_0000_0000; // +1
      corner[3]  = 64'hBFF0_0000_0000_0000; // -1
      corner[4]  = 64'h4000_0000_0000_0000; // +2
      corner[5]  = 64'hC000_0000_0000_0000; // -2
      corner[6]  = 64'h0000_0000_0000_0001; // tiny denormal
      corner[7]  = 64'h8000_0000_0000_0001; // negative tiny denormal
      corner[8]  = 64'h000F_FFFF_FFFF_FFFF; // largest denormal
      corner[9]  = 64'h0010_0000_0000_0000; // smallest normal
      corner[10] = 64'h7FEF_FFFF_FFFF_FFFF; // largest finite
      corner[11] = 64'h7FF0_0000_0000_0000; // +inf
      corner[12] = 64'hFFF0_0000_0000_0000; // -inf
      corner[13] = 64'h7FF8_0000_0000_0000; // quiet NaN
      corner[14] = 64'hFFF8_0000_0000_0001; // negative quiet NaN
      corner[15] = 64'h7FF0_0000_0000_0001; // signaling NaN
   end

   // returns {invalid, denorm, result}
   function automatic logic [65:0] model(input logic [1:0] f, input logic fl,
                                         input logic [63:0] a, input logic [63:0] b);
      logic da, db, na, nb, sa, sb, un, hit, inv, lt, eq;
      logic [63:0] ka, kb, xa, xb;
      da = (a[62:52] == 0) && (a[51:0] != 0);
      db = (b[62:52] == 0) && (b[51:0] != 0);
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      sa = na && !a[51];
      sb = nb && !b[51];
      xa = (fl && da) ? {a[63], 63'b0} : a;
      xb = (fl && db) ? {b[63], 63'b0} : b;
      if (xa[62:0] == 0) xa = 64'b0;
      if (xb[62:0] == 0) xb = 64'b0;
      ka = xa[63] ? ~xa : (xa | 64'h8000_0000_0000_0000);
      kb = xb[63] ? ~xb : (xb | 64'h8000_0000_0000_0000);
      lt = ka < kb;
      eq = ka == kb;
      un = na || nb;
      case (f)
         2'd0: hit = un;
         2'd1: hit = !un && eq;
         2'd2: hit = !un && lt;
         default: hit = !un && (lt || eq);
      endcase
      inv = un && (f[1] || sa || sb);
      return {inv, da || db, hit ? TRUE_W : 64'b0};
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic run_one(input logic [1:0] f, input logic fl,
                          input logic [63:0] a, input logic [63:0] b, input string tag);
      logic [65:0] e;
      func_sel = f; flush_den = fl; opa = a; opb = b; in_valid = 1'b1;
      e = model(f, fl, a, b);
      @(negedge clk);
      check($sformatf("%s R1 R10 out_valid f=%0d", tag, f), {63'b0, out_valid}, 64'd1);
      check($sformatf("%s R2 result f=%0d fl=%0d a=%h b=%h", tag, f, fl, a, b), result, e[63:0]);
      check($sformatf("R4 invalid f=%0d a=%h b=%h", f, a, b), {63'b0, flag_invalid}, {63'b0, e[65]});
      check($sformatf("R5 denorm a=%h b=%h", a, b), {63'b0, flag_denorm}, {63'b0, e[64]});
   endtask

   function automatic string tag_for(input logic fl, input logic [63:0] a, input logic [63:0] b);
      logic na, nb, da, db;
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      da = (a[62:52] == 0) && (a[51:0] != 0);
      db = (b[62:52] == 0) && (b[51:0] != 0);
      if (na || nb) return ((a[51] && na) || (b[51] && nb)) ? "R3 R8" : "R3 R8 snan";
      if (da || db) return fl ? "R6 flush" : "R6 keep";
      if (a[62:0] == 0 && b[62:0] == 0) return "R7";
      return "R9";
   endfunction

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check("R10 reset out_valid", {63'b0, out_valid}, 64'd0);
      check("R10 reset result", result, 64'd0);
      check("R10 reset flags", {62'b0, flag_invalid, flag_denorm}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed cases
      run_one(2'd1, 1'b0, 64'h0, 64'h8000_0000_0000_0000, "R7 eq");
      run_one(2'd2, 1'b0, 64'h8000_0000_0000_0000, 64'h0, "R7 lt");
      run_one(2'd2, 1'b0, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R9 neg");
      run_one(2'd1, 1'b0, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R8 quiet");
      run_one(2'd1, 1'b0, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, "R8 signaling");
      run_one(2'd3, 1'b1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, "R6 flushed");

      // idle cycle: out_valid must drop, outputs hold
      in_valid = 1'b0;
      @(negedge clk);
      check("R10 idle out_valid", {63'b0, out_valid}, 64'd0);

      // sweep of corners, every function and flush setting
      for (int f = 0; f < 4; f++)
         for (int fl = 0; fl < 2; fl++)
            for (int i = 0; i < 16; i++)
               for (int j = 0; j < 16; j++)
                  run_one(f[1:0], fl[0], corner[i], corner[j],
                          tag_for(fl[0], corner[i], corner[j]));

      // random pairs biased towards special exponents
      for (int k = 0; k < 3000; k++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         case ($urandom_range(0, 5))
            0: a[62:52] = 11'h000;
            1: a[62:52] = 11'h7FF;
            2: b[62:52] = 11'h000;
            3: b[62:52] = 11'h7FF;
            4: b = {~a[63], a[62:0]};
            default: ;
         endcase
         run_one(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), a, b, tag_for(1'b0, a, b));
      end

      in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule